// File: doc/BRIEF.md
# Segmented Context MMU Translator

This block translates a 32-bit processor bus through two levels of tables. Every access carries an address space identifier (ASI). Some identifiers reach the unit's own state directly: a context register, a system-enable register, a diagnostic LED register, the segment table and the page table. Identifiers 8 to 11 are translated accesses. The segment table is indexed by the current context and the segment number of the virtual address. It yields a page-group number. That group number, together with the page number of the address, selects one page table entry (PTE). A valid PTE is marked as accessed and gives a 16-bit frame number and a two-bit space type. The unit then issues a request to space 0 or space 1 at `{4'b0, frame, va[11:0]}`.

While the system-enable register shows boot state (its bit 7 is clear), supervisor instruction fetches (ASI 9) skip translation and are sent to the boot ROM at the unchanged virtual address. A translated access that hits an invalid entry never reaches memory. It raises a one-cycle fault and records the faulting address and direction. All tables are plain storage without reset. Every response is registered and appears one clock after the request.

Top module: `ctx_mmu`

## Requirements
- R1: After a synchronous active-low reset, all response outputs are 0 and the context, system-enable and diagnostic registers are 0, so the unit is in boot state.
- R2: With ASI 2, bits 31:28 of the address select a register: 3 is the context, 4 is system-enable and 7 is the diagnostic byte, which also drives `diag_o`. Writes take `wdata_i[31:24]`. Reads return the byte in bits 31:24 with `rd_valid_o`. Any other selector reads 0, and a write to it has no effect.
- R3: ASI 3 accesses the segment entry at index {context low CTX_W bits, va[18 +: SEG_W]}. With `be_i`=4'b1000 a write stores `wdata_i[31:24]` and a read returns the entry in bits 31:24. With 4'b1100 the write stores and the read returns bits 23:16. With any other lane pattern the write is dropped and the read returns 0.
- R4: ASI 4 accesses the PTE at index (segment entry low PMEG_W bits) × 64 + va[17:12]. A write updates only the bytes enabled in `be_i` (bit 3 is bits 31:24). A read returns all 32 bits.
- R5: An ASI 8–11 access that finds a PTE with bit 31 (valid) set raises `mem_req_o` with `mem_space_o` = PTE bit 26 when bits 27:26 are 0 or 1. It drives `bus_addr_o` = {4'b0, PTE[15:0], va[11:0]} and `mem_we_o` = `we_i`, and passes the data and lanes on a write. It also sets PTE bit 25 (accessed).
- R6: A valid PTE with type 2 or 3 issues no memory request. A read returns 0 with `rd_valid_o`, a write is dropped, and the accessed bit is still set.
- R7: A translated access to a PTE with bit 31 clear issues no memory request and pulses `fault_o` for one cycle. It latches the virtual address in `fault_va_o` and the direction (1 = write) in `fault_wr_o`. A read returns 0 with `rd_valid_o`.
- R8: In boot state an ASI 9 read raises `rom_req_o` with `bus_addr_o` = virtual address and no table lookup or accessed update. An ASI 9 write in boot state is dropped. Other translated identifiers translate normally in boot state.
- R9: Only the low CTX_W context bits, the low SEG_W segment bits and the low PMEG_W page-group bits take part in indexing, so values that differ only above them alias.
- R10: Every response, whether read data, memory request, ROM request or fault, appears exactly one clock after the request cycle and lasts one cycle.
- R11: A read with any other ASI returns 0 with `rd_valid_o`, and a write with one changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request this cycle |
| asi_i | input | 8 | Address space identifier |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte lanes, bit 3 = data bits 31:24 |
| vaddr_i | input | 32 | Virtual address |
| wdata_i | input | 32 | Write data |
| rd_valid_o | output | 1 | Locally answered read data valid |
| rdata_o | output | 32 | Read data (0 when not valid) |
| mem_req_o | output | 1 | Translated request to a memory space |
| mem_space_o | output | 1 | Target space (0 or 1) |
| mem_we_o | output | 1 | Direction of the memory request |
| bus_addr_o | output | 32 | Physical or ROM address |
| mem_wdata_o | output | 32 | Write data for a memory write |
| mem_be_o | output | 4 | Byte lanes for a memory write |
| rom_req_o | output | 1 | Boot ROM fetch |
| fault_o | output | 1 | One-cycle invalid-entry fault |
| fault_va_o | output | 32 | Virtual address of the last fault |
| fault_wr_o | output | 1 | Direction of the last fault |
| diag_o | output | 8 | Diagnostic LED byte |

## Verification
The assertions assume that `req_i` stays low while reset is held. They also assume that the ASI and address of a request are held only for its own cycle, so a registered response can be traced back with a one-cycle look-back. The stimulus drives requests only after reset is released. It writes every segment entry and PTE that it later reads or translates through, so no check depends on uninitialised table contents. Aliasing is exercised by setting context, segment and page-group bits above the masks on entries that were written earlier.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    // Identifiers with a fixed meaning
    localparam logic [7:0] ASI_SYS   = 8'd2;
    localparam logic [7:0] ASI_SEG   = 8'd3;
    localparam logic [7:0] ASI_PTE   = 8'd4;
    localparam logic [7:0] ASI_SFETCH = 8'd9;
    localparam logic [5:0] ASI_XL_HI = 6'd2;   // asi[7:2] of 8..11

    // System register selectors in va[31:28]
    localparam logic [3:0] SEL_CTX  = 4'd3;
    localparam logic [3:0] SEL_SYSEN = 4'd4;
    localparam logic [3:0] SEL_DIAG = 4'd7;

    // PTE fields
    localparam int PTE_VALID = 31;
    localparam int PTE_ACC   = 25;
    localparam int PTE_TYPE_LO = 26;
    localparam int PFN_W     = 16;
    localparam int PAGE_OFS_W = 12;
    localparam int PAGES_W   = 6;               // 64 entries per group
    localparam int SEG_LO    = PAGE_OFS_W + PAGES_W;
    localparam int SEG_ENTRY_W = 8;
    localparam int NOTBOOT_BIT = 7;

    // Lane patterns for segment entry access
    localparam logic [3:0] LANE_TOP  = 4'b1000;
    localparam logic [3:0] LANE_TOP2 = 4'b1100;
endpackage

// File: rtl/mmu_seg_table.sv
// Segment table: one page-group number per (context, segment).
// Assumes one write per cycle; read is combinational on the same index.
module mmu_seg_table #(
    parameter int IDX_W = 9
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [IDX_W-1:0]                    idx_i,
    input  logic                                wr_en_i,
    input  logic [mmu_pkg::SEG_ENTRY_W-1:0]     wr_data_i,
    output logic [mmu_pkg::SEG_ENTRY_W-1:0]     rd_data_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [mmu_pkg::SEG_ENTRY_W-1:0] mem [DEPTH];

    // Store the selected entry on a write
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[idx_i] <= wr_data_i;
    end

    // Present the indexed entry
    assign rd_data_o = mem[idx_i];

    // R3
    // seg_store_chk
    seg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> mem[$past(idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/mmu_page_table.sv
// Page table: 32-bit entries with byte-lane writes and an accessed-bit set.
// Assumes a lane write and an accessed set never coincide on one request.
module mmu_page_table #(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             wr_en_i,
    input  logic [3:0]       wr_be_i,
    input  logic [31:0]      wr_data_i,
    input  logic             acc_set_i,
    output logic [31:0]      rd_data_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [31:0] mem [DEPTH];

    // Merge enabled bytes, or mark the entry accessed
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            for (int b = 0; b < 4; b++) begin
                if (wr_be_i[b]) mem[idx_i][8*b +: 8] <= wr_data_i[8*b +: 8];
            end
        end else if (acc_set_i) begin
            mem[idx_i][mmu_pkg::PTE_ACC] <= 1'b1;
        end
    end

    // Present the indexed entry
    assign rd_data_o = mem[idx_i];

    // R5
    // acc_mark_chk
    acc_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_set_i && !wr_en_i) |=> mem[$past(idx_i)][mmu_pkg::PTE_ACC]);
endmodule

// File: rtl/ctx_mmu.sv
// Two-level context MMU: system registers, segment and page table access,
// translation with accessed marking, invalid-entry fault and boot ROM bypass.
// Assumes req_i is low during reset; all responses are registered (1 cycle).
module ctx_mmu
    import mmu_pkg::*;
#(
    parameter int CTX_W  = 3,
    parameter int SEG_W  = 6,
    parameter int PMEG_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic [7:0]  asi_i,
    input  logic        we_i,
    input  logic [3:0]  be_i,
    input  logic [31:0] vaddr_i,
    input  logic [31:0] wdata_i,
    output logic        rd_valid_o,
    output logic [31:0] rdata_o,
    output logic        mem_req_o,
    output logic        mem_space_o,
    output logic        mem_we_o,
    output logic [31:0] bus_addr_o,
    output logic [31:0] mem_wdata_o,
    output logic [3:0]  mem_be_o,
    output logic        rom_req_o,
    output logic        fault_o,
    output logic [31:0] fault_va_o,
    output logic        fault_wr_o,
    output logic [7:0]  diag_o
);
    localparam int SEG_IDX_W = CTX_W + SEG_W;
    localparam int PT_IDX_W  = PMEG_W + PAGES_W;

    logic [7:0] ctx_q, sysen_q, diag_q;
    logic [SEG_IDX_W-1:0] seg_idx;
    logic [PT_IDX_W-1:0]  pt_idx;
    logic [SEG_ENTRY_W-1:0] seg_rd, seg_wd;
    logic [31:0] pte_rd;
    logic seg_we, pte_we, acc_set;
    logic boot_fetch, is_xl, pte_ok, type_ok;
    logic [3:0] sel;

    logic        n_rdv, n_mreq, n_space, n_mwe, n_rom, n_fault;
    logic [31:0] n_rdata, n_addr, n_wdata;
    logic [3:0]  n_be;

    assign sel        = vaddr_i[31:28];
    assign seg_idx    = {ctx_q[CTX_W-1:0], vaddr_i[SEG_LO +: SEG_W]};
    assign pt_idx     = {seg_rd[PMEG_W-1:0], vaddr_i[PAGE_OFS_W +: PAGES_W]};
    assign boot_fetch = (asi_i == ASI_SFETCH) && !sysen_q[NOTBOOT_BIT];
    assign is_xl      = (asi_i[7:2] == ASI_XL_HI) && !boot_fetch;
    assign pte_ok     = pte_rd[PTE_VALID];
    assign type_ok    = !pte_rd[PTE_TYPE_LO+1];

    // Table write controls
    assign seg_we  = req_i && we_i && (asi_i == ASI_SEG) &&
                     (be_i == LANE_TOP || be_i == LANE_TOP2);
    assign seg_wd  = (be_i == LANE_TOP) ? wdata_i[31:24] : wdata_i[23:16];
    assign pte_we  = req_i && we_i && (asi_i == ASI_PTE);
    assign acc_set = req_i && is_xl && pte_ok;

    mmu_seg_table #(.IDX_W(SEG_IDX_W)) u_seg (
        .clk(clk), .rst_n(rst_n), .idx_i(seg_idx), .wr_en_i(seg_we),
        .wr_data_i(seg_wd), .rd_data_o(seg_rd)
    );

    mmu_page_table #(.IDX_W(PT_IDX_W)) u_pt (
        .clk(clk), .rst_n(rst_n), .idx_i(pt_idx), .wr_en_i(pte_we),
        .wr_be_i(be_i), .wr_data_i(wdata_i), .acc_set_i(acc_set),
        .rd_data_o(pte_rd)
    );

    // System register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q   <= '0;
            sysen_q <= '0;
            diag_q  <= '0;
        end else if (req_i && we_i && asi_i == ASI_SYS) begin
            case (sel)
                SEL_CTX:   ctx_q   <= wdata_i[31:24];
                SEL_SYSEN: sysen_q <= wdata_i[31:24];
                SEL_DIAG:  diag_q  <= wdata_i[31:24];
                default: ;
            endcase
        end
    end

    // Decide the response for this request
    always_comb begin
        n_rdv = 1'b0; n_rdata = '0; n_mreq = 1'b0; n_space = 1'b0;
        n_mwe = 1'b0; n_addr = '0; n_wdata = '0; n_be = '0;
        n_rom = 1'b0; n_fault = 1'b0;
        if (req_i) begin
            if (boot_fetch) begin
                n_rom  = !we_i;
                n_addr = we_i ? 32'd0 : vaddr_i;
            end else if (is_xl) begin
                if (pte_ok && type_ok) begin
                    n_mreq  = 1'b1;
                    n_space = pte_rd[PTE_TYPE_LO];
                    n_mwe   = we_i;
                    n_addr  = {{(32-PFN_W-PAGE_OFS_W){1'b0}}, pte_rd[PFN_W-1:0],
                               vaddr_i[PAGE_OFS_W-1:0]};
                    n_wdata = we_i ? wdata_i : 32'd0;
                    n_be    = we_i ? be_i : 4'd0;
                end else begin
                    n_rdv   = !we_i;
                    n_fault = !pte_ok;
                end
            end else if (!we_i) begin
                n_rdv = 1'b1;
                case (asi_i)
                    ASI_SYS: case (sel)
                        SEL_CTX:   n_rdata = {ctx_q, 24'd0};
                        SEL_SYSEN: n_rdata = {sysen_q, 24'd0};
                        SEL_DIAG:  n_rdata = {diag_q, 24'd0};
                        default:   n_rdata = '0;
                    endcase
                    ASI_SEG: begin
                        if (be_i == LANE_TOP)       n_rdata = {seg_rd, 24'd0};
                        else if (be_i == LANE_TOP2) n_rdata = {8'd0, seg_rd, 16'd0};
                    end
                    ASI_PTE: n_rdata = pte_rd;
                    default: n_rdata = '0;
                endcase
            end
        end
    end

    // Register the response and the fault record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0; rdata_o <= '0; mem_req_o <= 1'b0;
            mem_space_o <= 1'b0; mem_we_o <= 1'b0; bus_addr_o <= '0;
            mem_wdata_o <= '0; mem_be_o <= '0; rom_req_o <= 1'b0;
            fault_o <= 1'b0; fault_va_o <= '0; fault_wr_o <= 1'b0;
        end else begin
            rd_valid_o  <= n_rdv;   rdata_o  <= n_rdata;
            mem_req_o   <= n_mreq;  mem_space_o <= n_space;
            mem_we_o    <= n_mwe;   bus_addr_o  <= n_addr;
            mem_wdata_o <= n_wdata; mem_be_o    <= n_be;
            rom_req_o   <= n_rom;   fault_o     <= n_fault;
            if (n_fault) begin
                fault_va_o <= vaddr_i;
                fault_wr_o <= we_i;
            end
        end
    end

    assign diag_o = diag_q;

    // R7
    // fault_blocks_mem_chk
    fault_blocks_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (!mem_req_o && !rom_req_o));

    // R8
    // rom_only_sfetch_chk
    rom_only_sfetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req_o |-> (!mem_req_o && $past(asi_i) == ASI_SFETCH && !$past(we_i)));

    // R5
    // mem_from_xl_chk
    mem_from_xl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ($past(asi_i[7:2]) == ASI_XL_HI && $past(req_i)));

    // R10
    // no_orphan_resp_chk
    no_orphan_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o || mem_req_o || rom_req_o || fault_o) |-> $past(req_i));
endmodule

// File: tb/sim_ctx_mmu.sv
module sim_ctx_mmu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [7:0]  asi = '0;
    logic [3:0]  be = '0;
    logic [31:0] va = '0, wd = '0;
    logic        rd_valid, mem_req, mem_space, mem_we, rom_req, fault, fault_wr;
    logic [31:0] rdata, bus_addr, mem_wdata, fault_va;
    logic [3:0]  mem_be;
    logic [7:0]  diag;

    ctx_mmu u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .asi_i(asi), .we_i(we),
        .be_i(be), .vaddr_i(va), .wdata_i(wd), .rd_valid_o(rd_valid),
        .rdata_o(rdata), .mem_req_o(mem_req), .mem_space_o(mem_space),
        .mem_we_o(mem_we), .bus_addr_o(bus_addr), .mem_wdata_o(mem_wdata),
        .mem_be_o(mem_be), .rom_req_o(rom_req), .fault_o(fault),
        .fault_va_o(fault_va), .fault_wr_o(fault_wr), .diag_o(diag)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Reference model state
    int unsigned seg_m [int];
    int unsigned pte_m [int];
    int unsigned m_ctx = 0, m_sysen = 0, m_diag = 0, m_fva = 0, m_fwr = 0;
    logic [146:0] exp_v = '0;
    string prev_tag = "R1";
    int vectors = 0, miscompares = 0;
    bit done = 0;

    function automatic int seg_index(int unsigned a);
        return ((m_ctx & 7) << 6) | ((a >> 18) & 63);
    endfunction
    function automatic int pte_index(int unsigned a);
        return ((seg_m[seg_index(a)] & 7) * 64) + ((a >> 12) & 63);
    endfunction

    task automatic check();
        logic [146:0] act;
        act = {rd_valid, rdata, mem_req, mem_space, mem_we, bus_addr, mem_wdata,
               mem_be, rom_req, fault, fault_va, fault_wr, diag};
        vectors++;
        if (act !== exp_v) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", prev_tag, act, exp_v);
        end
    endtask

    // Compare last response, then drive the next request and predict it
    task automatic step(bit r, int unsigned a_s, bit w, logic [3:0] b,
                        int unsigned a, int unsigned d, string tag);
        bit          e_rdv = 0, e_mreq = 0, e_sp = 0, e_mwe = 0, e_rom = 0, e_flt = 0;
        int unsigned e_rd = 0, e_ad = 0, e_wd = 0, e_be = 0, p, pi, si, sel;
        @(negedge clk);
        check();
        req = r; asi = a_s[7:0]; we = w; be = b; va = a; wd = d;
        if (r) begin
            sel = a >> 28;
            if (a_s == 9 && (m_sysen & 8'h80) == 0) begin
                if (!w) begin e_rom = 1; e_ad = a; end
            end else if (a_s >= 8 && a_s <= 11) begin
                pi = pte_index(a); p = pte_m[pi];
                if (p[31]) begin
                    pte_m[pi] = p | 32'h0200_0000;
                    if (((p >> 26) & 3) < 2) begin
                        e_mreq = 1; e_sp = p[26]; e_mwe = w;
                        e_ad = ((p & 32'hFFFF) << 12) | (a & 32'hFFF);
                        if (w) begin e_wd = d; e_be = b; end
                    end else e_rdv = !w;
                end else begin
                    e_flt = 1; e_rdv = !w; m_fva = a; m_fwr = w;
                end
            end else if (a_s == 2) begin
                if (w) begin
                    if (sel == 3) m_ctx = d >> 24;
                    else if (sel == 4) m_sysen = d >> 24;
                    else if (sel == 7) m_diag = d >> 24;
                end else begin
                    e_rdv = 1;
                    e_rd = (sel == 3) ? m_ctx << 24 : (sel == 4) ? m_sysen << 24 :
                           (sel == 7) ? m_diag << 24 : 0;
                end
            end else if (a_s == 3) begin
                si = seg_index(a);
                if (w) begin
                    if (b == 4'b1000) seg_m[si] = (d >> 24) & 255;
                    else if (b == 4'b1100) seg_m[si] = (d >> 16) & 255;
                end else begin
                    e_rdv = 1;
                    e_rd = (b == 4'b1000) ? seg_m[si] << 24 :
                           (b == 4'b1100) ? seg_m[si] << 16 : 0;
                end
            end else if (a_s == 4) begin
                pi = pte_index(a);
                if (w) begin
                    p = pte_m.exists(pi) ? pte_m[pi] : 0;
                    for (int k = 0; k < 4; k++)
                        if (b[k]) p = (p & ~(32'hFF << (8*k))) | (d & (32'hFF << (8*k)));
                    pte_m[pi] = p;
                end else begin
                    e_rdv = 1; e_rd = pte_m[pi];
                end
            end else if (!w) e_rdv = 1;
        end
        exp_v = {e_rdv, e_rd, e_mreq, e_sp, e_mwe, e_ad, e_wd, e_be[3:0],
                 e_rom, e_flt, m_fva, m_fwr[0], m_diag[7:0]};
        prev_tag = tag;
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 4'h0, 0, 0, tag);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    localparam int unsigned SEG5 = 5 << 18;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle("R1");                                          // reset state
        step(1, 2, 0, 4'h8, 32'h4000_0000, 0, "R1");         // sysen reads 0
        step(1, 9, 0, 4'hF, 32'h0000_1234, 0, "R8");         // boot ROM fetch
        step(1, 9, 1, 4'hF, 32'h0000_1234, 32'h1, "R8");     // boot write dropped
        step(1, 2, 1, 4'h8, 32'h3000_0000, 32'h0200_0000, "R2");
        step(1, 2, 0, 4'h8, 32'h3000_0000, 0, "R2");
        step(1, 2, 1, 4'h8, 32'h7000_0000, 32'h5A00_0000, "R2");
        step(1, 2, 0, 4'h8, 32'h1000_0000, 0, "R2");         // unknown selector
        step(1, 3, 1, 4'h8, SEG5, 32'h03AA_BBCC, "R3");
        step(1, 3, 0, 4'h8, SEG5, 0, "R3");
        step(1, 3, 0, 4'hC, SEG5, 0, "R3");
        step(1, 3, 0, 4'h1, SEG5, 0, "R3");
        step(1, 3, 1, 4'hC, 6 << 18, 32'h0005_0000, "R3");
        step(1, 3, 1, 4'h3, 6 << 18, 32'h0709_0000, "R3");   // dropped lanes
        step(1, 3, 0, 4'h8, 6 << 18, 0, "R3");
        step(1, 4, 1, 4'hF, SEG5 | (7 << 12), 32'h8400_1234, "R4");
        step(1, 4, 1, 4'h1, SEG5 | (7 << 12), 32'h0000_00AB, "R4");
        step(1, 4, 0, 4'hF, SEG5 | (7 << 12), 0, "R4");
        step(1, 8, 0, 4'hF, SEG5 | (7 << 12) | 32'h456, 0, "R8"); // boot: ASI 8 translates
        step(1, 2, 1, 4'h8, 32'h4000_0000, 32'h8000_0000, "R2");
        step(1, 9, 0, 4'hF, SEG5 | (7 << 12) | 32'h456, 0, "R5");
        step(1, 4, 0, 4'hF, SEG5 | (7 << 12), 0, "R5");      // accessed set
        step(1, 10, 1, 4'h6, SEG5 | (7 << 12) | 32'h0FC, 32'hDEAD_BEEF, "R5");
        step(1, 4, 1, 4'hF, SEG5 | (8 << 12), 32'h8000_0077, "R5");
        step(1, 11, 0, 4'hF, SEG5 | (8 << 12) | 32'h010, 0, "R5");
        step(1, 4, 1, 4'hF, SEG5 | (9 << 12), 32'h8800_0001, "R6");
        step(1, 8, 0, 4'hF, SEG5 | (9 << 12), 0, "R6");
        step(1, 8, 1, 4'hF, SEG5 | (9 << 12), 32'h1234_5678, "R6");
        step(1, 4, 0, 4'hF, SEG5 | (9 << 12), 0, "R6");
        step(1, 4, 1, 4'hF, SEG5 | (10 << 12), 32'h0000_0042, "R7");
        step(1, 8, 0, 4'hF, SEG5 | (10 << 12) | 32'h344, 0, "R7");
        idle("R7");                                          // pulse ends
        step(1, 9, 1, 4'hF, SEG5 | (10 << 12) | 32'h88, 32'h5, "R7");
        idle("R10");
        step(1, 2, 1, 4'h8, 32'h3000_0000, 32'h0A00_0000, "R9");
        step(1, 3, 0, 4'h8, SEG5, 0, "R9");                  // ctx alias
        step(1, 3, 0, 4'h8, SEG5 | (1 << 24), 0, "R9");      // segment alias
        step(1, 3, 1, 4'h8, 7 << 18, 32'h0B00_0000, "R9");
        step(1, 3, 1, 4'h8, 8 << 18, 32'h0300_0000, "R9");
        step(1, 4, 1, 4'hF, 7 << 18, 32'h8400_0999, "R9");
        step(1, 4, 0, 4'hF, 8 << 18, 0, "R9");               // group alias
        step(1, 5, 1, 4'hF, 32'h3000_0000, 32'hFF00_0000, "R11");
        step(1, 5, 0, 4'hF, 32'h3000_0000, 0, "R11");
        step(1, 2, 0, 4'h8, 32'h3000_0000, 0, "R11");
        step(1, 2, 0, 4'h8, 32'h4000_0000, 0, "R11");
        step(1, 2, 1, 4'h8, 32'h4000_0000, 32'h0000_0000, "R8");
        step(1, 9, 0, 4'hF, SEG5 | (7 << 12), 0, "R8");      // boot again
        idle("R10");
        idle("R10");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule